// File: doc/BRIEF.md
# Sliding-Window Complex Interference Canceller

This block removes interference from a main receive channel when the same interference is also picked up on an auxiliary channel. Each input beat carries one main sample `vm` and one auxiliary sample `va`, both complex and given as separate signed real and imaginary words. The block keeps two running sums over the most recent `WIN` accepted beats. The first is the cross-correlation of `vm` with the conjugate of `va`. The second is the power of `va`, which is real.

From these sums it forms a complex weight: the cross-correlation sum divided by the power sum, in fixed point with `FRAC` fractional bits. It then applies the weight to the current beat right away, producing the residual `vm - w*va`. A sequential divider produces the weight, so the block accepts one beat at a time and holds off the source with `in_ready` while the divider runs. A result pulse on `out_valid` presents the residual, the weight and a flag that marks an empty power sum.

Top module: `intf_canceller`

## Requirements
- R1: `in_ready` is high while the block is idle. It falls in the cycle after a beat is accepted and rises again together with the result pulse, QW+2 rising edges after the accepting edge, where QW = 2*IW+5+FRAC. `out_valid` is high for a single cycle.
- R2: After reset, the first WIN-1 accepted beats produce no `out_valid` pulse. Every accepted beat after that produces exactly one.
- R3: The correlation sum covers the last WIN accepted beats. Its real part sums vr*ar+vi*ai and its imaginary part sums vi*ar-vr*ai. The power sum adds ar*ar+ai*ai over the same beats.
- R4: Each component of `w_re`/`w_im` equals the correlation component times 2^FRAC divided by the power sum, truncated toward zero. It is a signed word of QW+1 bits.
- R5: When the power sum is zero, both weight words are zero, `w_zero` is high and the residual equals `vm`.
- R6: Let (wr,wi) be the weight and (ar,ai) the current auxiliary sample. The residual real part is vr - floor((wr*ar - wi*ai) / 2^FRAC). The imaginary part is vi - floor((wr*ai + wi*ar) / 2^FRAC).
- R7: Each residual component is clamped to the range -2^(OW-1) .. 2^(OW-1)-1.
- R8: During and right after reset, `in_ready` is 1 and `out_valid` is 0.
- R9: Raising `in_valid` while `in_ready` is low has no effect on the window or on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| vm_re | input | IW | Main sample, real part (signed) |
| vm_im | input | IW | Main sample, imaginary part (signed) |
| va_re | input | IW | Auxiliary sample, real part (signed) |
| va_im | input | IW | Auxiliary sample, imaginary part (signed) |
| out_valid | output | 1 | One-cycle result pulse |
| out_re | output | OW | Residual, real part (signed, clamped) |
| out_im | output | OW | Residual, imaginary part (signed, clamped) |
| w_re | output | QW+1 | Weight, real part, FRAC fractional bits |
| w_im | output | QW+1 | Weight, imaginary part, FRAC fractional bits |
| w_zero | output | 1 | Power sum was zero; weight forced to zero |

## Verification
The bench builds the block with IW=10, OW=10, FRAC=10 and WIN=9. This gives QW=35, so each beat takes about forty cycles, and a few hundred beats fit easily within the run. Setting OW equal to IW means that a weight above one, applied against a main sample of the opposite sign, overruns the output range, so the clamp is reached by a short directed sequence as well as by random beats. The 9-beat window is filled, drained and refilled across two resets. This covers the warm-up gap, the eviction of the oldest beat, and a window made only of zero auxiliary samples.

// File: rtl/canc_pkg.sv
`timescale 1ns/1ps
package canc_pkg;
  // Sequencing of one accepted beat through the canceller.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // waiting for a beat
    ST_LOAD = 2'd1,   // window sums updated, start the divider
    ST_DIV  = 2'd2    // divider iterating, result on completion
  } canc_state_e;
endpackage

// File: rtl/canc_window.sv
`timescale 1ns/1ps
// Running correlation and power sums over the last WIN pushed beats.
module canc_window #(
  parameter int IW  = 12,
  parameter int WIN = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic signed [IW-1:0] vm_re,
  input  logic signed [IW-1:0] vm_im,
  input  logic signed [IW-1:0] va_re,
  input  logic signed [IW-1:0] va_im,
  output logic signed [2*IW+4:0] num_re,
  output logic signed [2*IW+4:0] num_im,
  output logic        [2*IW+4:0] den,
  output logic                 full
);
  localparam int PW = 2*IW + 1;           // product width
  localparam int AW = PW + 4;             // accumulator width, 4 guard bits
  localparam int CW = $clog2(WIN + 1);

  typedef struct packed {
    logic signed [PW-1:0] xr;
    logic signed [PW-1:0] xi;
    logic signed [PW-1:0] pw;
  } term_t;

  // main * conj(aux), and |aux|^2, from four plus two real multiplies
  function automatic term_t conj_terms(input logic signed [IW-1:0] mr,
                                       input logic signed [IW-1:0] mi,
                                       input logic signed [IW-1:0] ar,
                                       input logic signed [IW-1:0] ai);
    term_t t;
    t.xr = PW'(mr) * PW'(ar) + PW'(mi) * PW'(ai);
    t.xi = PW'(mi) * PW'(ar) - PW'(mr) * PW'(ai);
    t.pw = PW'(ar) * PW'(ar) + PW'(ai) * PW'(ai);
    return t;
  endfunction

  term_t                fresh;
  term_t                line_q [WIN];
  logic signed [AW-1:0] acc_xr_q, acc_xi_q, acc_pw_q;
  logic [CW-1:0]        fill_q;

  assign fresh = conj_terms(vm_re, vm_im, va_re, va_im);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < WIN; k++) line_q[k] <= '0;
      acc_xr_q <= '0;
      acc_xi_q <= '0;
      acc_pw_q <= '0;
      fill_q   <= '0;
    end else if (push) begin
      line_q[0] <= fresh;
      for (int k = 1; k < WIN; k++) line_q[k] <= line_q[k-1];
      acc_xr_q <= acc_xr_q + AW'(fresh.xr) - AW'(line_q[WIN-1].xr);
      acc_xi_q <= acc_xi_q + AW'(fresh.xi) - AW'(line_q[WIN-1].xi);
      acc_pw_q <= acc_pw_q + AW'(fresh.pw) - AW'(line_q[WIN-1].pw);
      if (fill_q != CW'(WIN)) fill_q <= fill_q + CW'(1);
    end
  end

  assign num_re = acc_xr_q;
  assign num_im = acc_xi_q;
  assign den    = acc_pw_q;
  assign full   = (fill_q == CW'(WIN));
endmodule

// File: rtl/canc_divider.sv
`timescale 1ns/1ps
// Restoring divider: two signed numerators over one non-negative denominator,
// quotient scaled by 2^FRAC and truncated toward zero. QW iterations.
module canc_divider #(
  parameter int AW   = 29,
  parameter int FRAC = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [AW-1:0]     num_re,
  input  logic signed [AW-1:0]     num_im,
  input  logic        [AW-1:0]     den,
  output logic                     busy,
  output logic                     done,
  output logic                     den_zero,
  output logic signed [AW+FRAC:0]  q_re,
  output logic signed [AW+FRAC:0]  q_im
);
  localparam int QW = AW + FRAC;
  localparam int WW = QW + 1;
  localparam int KW = $clog2(QW + 1);

  function automatic logic [AW-1:0] mag(input logic signed [AW-1:0] x);
    logic [AW-1:0] m;
    m = x[AW-1] ? AW'(-x) : AW'(x);
    return m;
  endfunction

  // one restoring step: shift in next dividend bit, trial subtract
  function automatic logic [AW+QW-1:0] step(input logic [AW-1:0] r,
                                            input logic [QW-1:0] q,
                                            input logic [AW-1:0] d);
    logic [AW:0] t;
    logic        b;
    t = {r, q[QW-1]};
    b = (t >= {1'b0, d});
    if (b) t = t - {1'b0, d};
    return {t[AW-1:0], q[QW-2:0], b};
  endfunction

  logic signed [AW-1:0] nsel [2];
  logic [AW-1:0]        dsr_q;
  logic [KW-1:0]        cnt_q;
  logic                 dz_q;

  assign nsel[0] = num_re;
  assign nsel[1] = num_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
      dsr_q <= '0;
      dz_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= KW'(QW);
        dsr_q <= den;
        dz_q  <= (den == '0);
      end else if (busy) begin
        cnt_q <= cnt_q - KW'(1);
        if (cnt_q == KW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [AW-1:0]        rem_q;
    logic [QW-1:0]        quo_q;
    logic                 neg_q;
    logic signed [WW-1:0] q_lane;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rem_q <= '0;
        quo_q <= '0;
        neg_q <= 1'b0;
      end else if (start) begin
        rem_q <= '0;
        quo_q <= {mag(nsel[l]), {FRAC{1'b0}}};
        neg_q <= nsel[l][AW-1];
      end else if (busy) begin
        {rem_q, quo_q} <= step(rem_q, quo_q, dsr_q);
      end
    end

    assign q_lane = dz_q  ? '0 :
                    neg_q ? -$signed({1'b0, quo_q}) : $signed({1'b0, quo_q});
  end

  assign q_re     = g_lane[0].q_lane;
  assign q_im     = g_lane[1].q_lane;
  assign den_zero = dz_q;
endmodule

// File: rtl/canc_residual.sv
`timescale 1ns/1ps
// Residual vm - (w*va >>> FRAC), clamped to OW bits per component.
module canc_residual #(
  parameter int IW   = 12,
  parameter int WW   = 44,
  parameter int FRAC = 14,
  parameter int OW   = 14
) (
  input  logic signed [IW-1:0] vm_re,
  input  logic signed [IW-1:0] vm_im,
  input  logic signed [IW-1:0] va_re,
  input  logic signed [IW-1:0] va_im,
  input  logic signed [WW-1:0] w_re,
  input  logic signed [WW-1:0] w_im,
  output logic signed [OW-1:0] r_re,
  output logic signed [OW-1:0] r_im,
  output logic                 sat_re,
  output logic                 sat_im
);
  localparam int MW = WW + IW + 1;
  localparam int DW = MW + 1;

  // (w1*a1 +/- w2*a2) >>> FRAC
  function automatic logic signed [MW-1:0] scaled(input logic signed [WW-1:0] w1,
                                                  input logic signed [IW-1:0] a1,
                                                  input logic signed [WW-1:0] w2,
                                                  input logic signed [IW-1:0] a2,
                                                  input logic             add);
    logic signed [MW-1:0] p1, p2, s;
    p1 = MW'(w1) * MW'(a1);
    p2 = MW'(w2) * MW'(a2);
    s  = add ? (p1 + p2) : (p1 - p2);
    return s >>> FRAC;
  endfunction

  // clamp to OW bits; returns {saturated, value}
  function automatic logic [OW:0] clamp(input logic signed [DW-1:0] d);
    logic [DW-OW:0] hi;
    hi = d[DW-1:OW-1];
    if (hi == '0 || hi == '1) return {1'b0, d[OW-1:0]};
    else if (d[DW-1])         return {1'b1, 1'b1, {(OW-1){1'b0}}};
    else                      return {1'b1, 1'b0, {(OW-1){1'b1}}};
  endfunction

  logic signed [MW-1:0] cr, ci;
  logic signed [DW-1:0] dr, di;

  assign cr = scaled(w_re, va_re, w_im, va_im, 1'b0);
  assign ci = scaled(w_re, va_im, w_im, va_re, 1'b1);
  assign dr = DW'(vm_re) - DW'(cr);
  assign di = DW'(vm_im) - DW'(ci);
  assign {sat_re, r_re} = clamp(dr);
  assign {sat_im, r_im} = clamp(di);
endmodule

// File: rtl/intf_canceller.sv
`timescale 1ns/1ps
module intf_canceller
  import canc_pkg::*;
#(
  parameter int IW   = 12,
  parameter int OW   = 14,
  parameter int FRAC = 14,
  parameter int WIN  = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic signed [IW-1:0]           vm_re,
  input  logic signed [IW-1:0]           vm_im,
  input  logic signed [IW-1:0]           va_re,
  input  logic signed [IW-1:0]           va_im,
  output logic                           out_valid,
  output logic signed [OW-1:0]           out_re,
  output logic signed [OW-1:0]           out_im,
  output logic signed [2*IW+5+FRAC:0]    w_re,
  output logic signed [2*IW+5+FRAC:0]    w_im,
  output logic                           w_zero
);
  localparam int AW = 2*IW + 5;
  localparam int QW = AW + FRAC;
  localparam int WW = QW + 1;

  canc_state_e state_q;

  // named internal events
  logic accept, div_start, div_done, div_busy, win_full, den_zero, sat_re, sat_im;

  logic signed [IW-1:0] hvm_re, hvm_im, hva_re, hva_im;
  logic signed [AW-1:0] num_re, num_im;
  logic        [AW-1:0] den;
  logic signed [WW-1:0] q_re, q_im;
  logic signed [OW-1:0] r_re, r_im;

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign div_start = (state_q == ST_LOAD);

  canc_window #(.IW(IW), .WIN(WIN)) u_window (
    .clk(clk), .rst_n(rst_n), .push(accept),
    .vm_re(vm_re), .vm_im(vm_im), .va_re(va_re), .va_im(va_im),
    .num_re(num_re), .num_im(num_im), .den(den), .full(win_full)
  );

  canc_divider #(.AW(AW), .FRAC(FRAC)) u_divider (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num_re(num_re), .num_im(num_im), .den(den),
    .busy(div_busy), .done(div_done), .den_zero(den_zero),
    .q_re(q_re), .q_im(q_im)
  );

  canc_residual #(.IW(IW), .WW(WW), .FRAC(FRAC), .OW(OW)) u_residual (
    .vm_re(hvm_re), .vm_im(hvm_im), .va_re(hva_re), .va_im(hva_im),
    .w_re(q_re), .w_im(q_im),
    .r_re(r_re), .r_im(r_im), .sat_re(sat_re), .sat_im(sat_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      hvm_re    <= '0;
      hvm_im    <= '0;
      hva_re    <= '0;
      hva_im    <= '0;
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      w_re      <= '0;
      w_im      <= '0;
      w_zero    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          hvm_re  <= vm_re;
          hvm_im  <= vm_im;
          hva_re  <= va_re;
          hva_im  <= va_im;
          state_q <= ST_LOAD;
        end
        ST_LOAD: state_q <= ST_DIV;
        ST_DIV: if (div_done) begin
          out_re    <= r_re;
          out_im    <= r_im;
          w_re      <= q_re;
          w_im      <= q_im;
          w_zero    <= den_zero;
          out_valid <= win_full;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/canc_checker.sv
`timescale 1ns/1ps
module canc_checker #(
  parameter int IW  = 12,
  parameter int OW  = 14,
  parameter int WW  = 44,
  parameter int WIN = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic signed [IW-1:0] vm_re,
  input logic signed [IW-1:0] vm_im,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_re,
  input logic signed [OW-1:0] out_im,
  input logic signed [WW-1:0] w_re,
  input logic signed [WW-1:0] w_im,
  input logic                 w_zero,
  input logic                 div_done,
  input logic                 div_busy,
  input logic                 sat_re,
  input logic                 sat_im
);
  localparam logic signed [OW-1:0] OMAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] OMIN = {1'b1, {(OW-1){1'b0}}};

  int                   acc_q;
  logic signed [IW-1:0] seen_re, seen_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 0;
      seen_re <= '0;
      seen_im <= '0;
    end else if (in_valid && in_ready) begin
      if (acc_q < WIN) acc_q <= acc_q + 1;
      seen_re <= vm_re;
      seen_im <= vm_im;
    end
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r1_after_divide: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(div_done) && in_ready));

  a_r2_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc_q >= WIN));

  a_r5_zero_weight: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && w_zero) |-> (w_re == '0 && w_im == '0 &&
                               out_re == OW'(seen_re) && out_im == OW'(seen_im)));

  a_r7_clamp_re: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sat_re)) |-> (out_re == OMAX || out_re == OMIN));

  a_r7_clamp_im: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sat_im)) |-> (out_im == OMAX || out_im == OMIN));

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !in_ready);
endmodule

bind intf_canceller canc_checker #(
  .IW(IW), .OW(OW), .WW(WW), .WIN(WIN)
) u_canc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .vm_re(vm_re), .vm_im(vm_im), .out_valid(out_valid),
  .out_re(out_re), .out_im(out_im), .w_re(w_re), .w_im(w_im), .w_zero(w_zero),
  .div_done(div_done), .div_busy(div_busy), .sat_re(sat_re), .sat_im(sat_im)
);

// File: tb/test_intf_canceller.sv
`timescale 1ns/1ps
module test_intf_canceller;
  localparam int IW   = 10;
  localparam int OW   = 10;
  localparam int FRAC = 10;
  localparam int WIN  = 9;
  localparam int QW   = 2*IW + 5 + FRAC;
  localparam int WW   = QW + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n, in_valid, in_ready, out_valid, w_zero;
  logic signed [IW-1:0] vm_re, vm_im, va_re, va_im;
  logic signed [OW-1:0] out_re, out_im;
  logic signed [WW-1:0] w_re, w_im;

  intf_canceller #(.IW(IW), .OW(OW), .FRAC(FRAC), .WIN(WIN)) i_intf_canceller (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .vm_re(vm_re), .vm_im(vm_im), .va_re(va_re), .va_im(va_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .w_re(w_re), .w_im(w_im), .w_zero(w_zero)
  );

  int nchk = 0, nfail = 0, nsat = 0, nzero = 0, nsent = 0;
  longint qvr[$], qvi[$], qar[$], qai[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampo(input longint v);
    longint lim = longint'(1) <<< (OW-1);
    if (v > lim - 1) return lim - 1;
    if (v < -lim)    return -lim;
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    vm_re = '0; vm_im = '0; va_re = '0; va_im = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(in_ready == 1'b1, "R8 in_ready", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R8 out_valid", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R8 in_ready after release", longint'(in_ready), 1);
    qvr.delete(); qvi.delete(); qar.delete(); qai.delete();
    nsent = 0;
  endtask

  // send one beat and check everything it produces; poke drives junk while busy (R9)
  task automatic send(input int vr, input int vi, input int ar, input int ai, input bit poke);
    longint nr, ni, d, wr, wi, pr, pi, er, ei;
    int n, seen_n;
    bit seen;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    vm_re = IW'(vr); vm_im = IW'(vi); va_re = IW'(ar); va_im = IW'(ai);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    qvr.push_back(vr); qvi.push_back(vi); qar.push_back(ar); qai.push_back(ai);
    if (qvr.size() > WIN) begin
      void'(qvr.pop_front()); void'(qvi.pop_front());
      void'(qar.pop_front()); void'(qai.pop_front());
    end
    nsent++;
    // R1: ready drops right after acceptance
    check(in_ready == 1'b0, "R1 ready low after accept", longint'(in_ready), 0);
    n = 1; seen = 1'b0; seen_n = 0;
    forever begin
      if (out_valid) begin seen = 1'b1; seen_n = n; end
      if (in_ready || n > QW + 20) break;
      if (poke && n == 3) begin
        in_valid = 1'b1;
        vm_re = IW'(-512); vm_im = IW'(511); va_re = IW'(300); va_im = IW'(-77);
      end
      if (poke && n == 4) in_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
    if (nsent < WIN) begin
      check(!seen, "R2 no result during warm-up", longint'(seen), 0);
    end else begin
      check(seen, "R2 result present", longint'(seen), 1);
      check(seen_n == QW + 3, "R1 latency", seen_n, QW + 3);
      // R3: window sums from the last WIN beats
      nr = 0; ni = 0; d = 0;
      foreach (qvr[k]) begin
        nr += qvr[k]*qar[k] + qvi[k]*qai[k];
        ni += qvi[k]*qar[k] - qvr[k]*qai[k];
        d  += qar[k]*qar[k] + qai[k]*qai[k];
      end
      // R4 / R5: weight
      if (d == 0) begin wr = 0; wi = 0; nzero++; end
      else begin
        wr = (nr * (longint'(1) <<< FRAC)) / d;
        wi = (ni * (longint'(1) <<< FRAC)) / d;
      end
      check(longint'(w_re) == wr, "R3/R4 weight real", longint'(w_re), wr);
      check(longint'(w_im) == wi, "R3/R4 weight imag", longint'(w_im), wi);
      check(w_zero == (d == 0), "R5 zero flag", longint'(w_zero), longint'(d == 0));
      // R6 / R7: residual
      pr = (wr*ar - wi*ai) >>> FRAC;
      pi = (wr*ai + wi*ar) >>> FRAC;
      er = clampo(vr - pr);
      ei = clampo(vi - pi);
      if (er != vr - pr || ei != vi - pi) nsat++;
      check(longint'(out_re) == er, "R6/R7 residual real", longint'(out_re), er);
      check(longint'(out_im) == ei, "R6/R7 residual imag", longint'(out_im), ei);
    end
  endtask

  function automatic int rnd_full();
    return int'($urandom_range(1023)) - 512;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R5: auxiliary silent for a whole window -> zero weight, residual = vm
    for (int k = 0; k < WIN + 2; k++) send(rnd_full(), rnd_full(), 0, 0, 1'b0);
    check(nzero >= 3, "R5 zero windows seen", nzero, 3);

    // R7: large weight against an opposite-sign aux beat overruns the output
    do_reset();
    for (int k = 0; k < WIN - 1; k++) send(511, 0, 1, 0, 1'b0);
    send(511, 0, -1, 0, 1'b0);
    check(longint'(out_re) == 511, "R7 clamp high", longint'(out_re), 511);
    send(-512, 0, 1, 0, 1'b0);

    // extremes, with junk during busy (R9)
    for (int k = 0; k < 12; k++) send(-512, -512, -512, (k % 2 == 0) ? -512 : 511, 1'b1);

    // random mix: full-scale and tiny auxiliary beats, occasional junk while busy
    for (int k = 0; k < 180; k++) begin
      int ar, ai;
      if ($urandom_range(3) == 0) begin
        ar = int'($urandom_range(4)) - 2; ai = int'($urandom_range(4)) - 2;
      end else begin
        ar = rnd_full(); ai = rnd_full();
      end
      send(rnd_full(), rnd_full(), ar, ai, $urandom_range(3) == 0);
    end
    check(nsat > 0, "R7 clamp exercised", nsat, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule